// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns a bus address into four chip-select pins: one for an I/O area, one for program memory and two general-purpose selects. Every select reads its own small set of configuration fields: enable, the strobe that qualifies it, the pin polarity, the decoded size, the base address and a stretch request. A byte-wide register write port loads these fields. The decoder is combinational from the address to the pins, and only the configuration is held in flops.

When regions overlap, one winner is chosen. The I/O select always wins. A configuration bit decides whether the program select or the general-purpose selects come next. Between the two general-purpose selects, select 1 ranks above select 2. A winning general-purpose select can also be ORed onto another pin. The block reports the stretch field of the winner so that an external timing generator can add E clocks. Each general-purpose select compares against either the 16-bit CPU address or the 19-bit expanded address.

Top module: `chip_sel_decode`

## Requirements
- R1: A write with `cfg_we` high loads `cfg_wdata` into the register at `cfg_addr` on the rising clock edge, and the new value governs the pins after that edge. The register offsets are: 0 I/O control, 1 program control, 2 GP1 control, 3 GP1 routing, 4 GP1 base, 5 GP2 control, 6 GP2 routing, 7 GP2 base. After reset every register is 0x00 except program control, which is 0x01. With these values the I/O select is disabled, the program select is enabled over 64 KB, both GP selects are disabled and every stretch field is 0.
- R2: I/O control has these fields: bit0 enable, bit1 qualify, bit2 polarity, bit3 size, bits5:4 stretch. Size 0 decodes CPU addresses 0x0000–0x1FFF. Size 1 decodes 0x1000–0x1FFF.
- R3: On the I/O and GP selects, qualify=1 lets the select assert whenever `addr_valid` is high. Qualify=0 requires both `addr_valid` and `e_high`. The program select needs only `addr_valid`. With `addr_valid` low, no select is active.
- R4: On the I/O and GP selects, polarity=1 makes the pin active high and polarity=0 makes it active low. The program pin `sel_prog` is always active low. The GP polarity bit is bit5 of GP control.
- R5: Program control has these fields: bit0 enable, bits2:1 size, bits4:3 stretch, bit5 GP-first. The size codes map to regions as follows: 0 = 0x0000–0xFFFF, 1 = 0x8000–0xFFFF, 2 = 0xC000–0xFFFF, 3 = 0xE000–0xFFFF.
- R6: GP control has these fields: bits3:0 size code, bit4 qualify, bit5 polarity, bits7:6 stretch. Code n in 1..9 decodes a window of 2^(n+10) bytes, from 2 KB up to 512 KB. Code 0 or any code above 9 disables the select. The GP base register holds address bits 18:11. Base bits that fall inside the window size are ignored in the compare.
- R7: GP routing bit0 selects the compare address. A value of 1 compares against `ext_addr`. A value of 0 compares against `cpu_addr` zero-extended to 19 bits.
- R8: At most one select wins. The I/O select beats all others. With GP-first=0 the program select beats both GP selects. With GP-first=1 both GP selects beat the program select. GP1 always beats GP2. Only the winner drives its own pin active.
- R9: GP routing bit1 ORs a winning GP select onto the program pin as well. GP1 routing bit2 ORs a winning GP1 onto the GP2 pin. The merged select still drives its own pin. Polarity is applied after merging.
- R10: `stretch` equals the stretch field of the winning select. It is 0 when no select wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_addr | input | 16 | CPU address |
| ext_addr | input | 19 | Expanded address |
| addr_valid | input | 1 | Address valid strobe |
| e_high | input | 1 | E clock high phase |
| sel_io | output | 1 | I/O select pin, level set by its polarity |
| sel_prog | output | 1 | Program select pin, active low |
| sel_gp1 | output | 1 | GP select 1 pin, level set by its polarity |
| sel_gp2 | output | 1 | GP select 2 pin, level set by its polarity |
| stretch | output | 2 | Extra E clocks requested by the winner |

## Verification
Addresses are placed on both sides of every region edge: the 8 KB and 4 KB I/O windows, the four program sizes, and a GP window whose base carries low bits that must be ignored. A wrong size mask or a wrong boundary comparison therefore shows up as a miss or a false hit. Overlap patterns switch the GP-first bit and put the two GP selects on top of each other. These patterns tell the priority order apart from the merge paths, because the `stretch` value names the winner even when a merge has activated a second pin. Toggling `e_high` and `addr_valid` under both qualify settings separates the two strobe modes. Repeating the same CPU address with different `ext_addr` values shows which address source a GP select compares against.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int CPU_AW   = 16;
  localparam int EXT_AW   = 19;
  localparam int GRAN_LOG = 11;
  localparam int BASE_W   = EXT_AW - GRAN_LOG;
  localparam int GP_NSIZE = 9;
  localparam int NREG     = 8;
  localparam int RAW      = $clog2(NREG);

  typedef struct packed {
    logic       en;
    logic       qual_any;
    logic       pol_hi;
    logic       size4k;
    logic [1:0] stretch;
  } io_cfg_t;

  typedef struct packed {
    logic       en;
    logic [1:0] size;
    logic [1:0] stretch;
    logic       gp_first;
  } prog_cfg_t;

  typedef struct packed {
    logic [3:0]        size;
    logic              qual_any;
    logic              pol_hi;
    logic [1:0]        stretch;
    logic              use_ext;
    logic              to_prog;
    logic              to_gp2;
    logic [BASE_W-1:0] base;
  } gp_cfg_t;

  function automatic logic strobe_ok(logic qual_any, logic av, logic e);
    return qual_any ? av : (av & e);
  endfunction

  function automatic logic io_region(logic [CPU_AW-1:0] a, logic size4k);
    return size4k ? (a[CPU_AW-1:12] == 4'h1) : (a[CPU_AW-1:13] == 3'b000);
  endfunction

  function automatic logic prog_region(logic [CPU_AW-1:0] a, logic [1:0] size);
    logic r;
    case (size)
      2'd0:    r = 1'b1;
      2'd1:    r = a[15];
      2'd2:    r = (a[15:14] == 2'b11);
      default: r = (a[15:13] == 3'b111);
    endcase
    return r;
  endfunction

  function automatic logic gp_region(logic [EXT_AW-1:0] a, logic [3:0] size,
                                     logic [BASE_W-1:0] base);
    logic [BASE_W-1:0] mask;
    if (size == 4'd0 || size > 4'(GP_NSIZE)) return 1'b0;
    mask = {BASE_W{1'b1}} << (size - 4'd1);
    return ((a[EXT_AW-1:GRAN_LOG] ^ base) & mask) == '0;
  endfunction
endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
  import csd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [RAW-1:0]        addr,
  input  logic [7:0]            wdata,
  output logic [NREG-1:0][7:0]  regs
);
  function automatic logic [7:0] reset_byte(int idx);
    return (idx == 1) ? 8'h01 : 8'h00;
  endfunction

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[i] <= reset_byte(i);
      else if (we && addr == RAW'(i))    regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/csd_gp_match.sv
module csd_gp_match
  import csd_pkg::*;
(
  input  gp_cfg_t            cfg,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [EXT_AW-1:0]  ext_addr,
  input  logic               addr_valid,
  input  logic               e_high,
  output logic               hit
);
  logic [EXT_AW-1:0] cmp_addr;
  assign cmp_addr = cfg.use_ext ? ext_addr
                                : {{(EXT_AW-CPU_AW){1'b0}}, cpu_addr};
  assign hit = strobe_ok(cfg.qual_any, addr_valid, e_high)
             & gp_region(cmp_addr, cfg.size, cfg.base);
endmodule

// File: rtl/csd_arbiter.sv
module csd_arbiter
  import csd_pkg::*;
(
  input  logic       hit_io,
  input  logic       hit_prog,
  input  logic       hit_gp1,
  input  logic       hit_gp2,
  input  io_cfg_t    io_cfg,
  input  prog_cfg_t  prog_cfg,
  input  gp_cfg_t    gp1_cfg,
  input  gp_cfg_t    gp2_cfg,
  output logic [3:0] wins,
  output logic       pin_io,
  output logic       pin_prog,
  output logic       pin_gp1,
  output logic       pin_gp2,
  output logic [1:0] stretch
);
  logic rest, w_io, w_prog, w_gp1, w_gp2;
  logic act_prog, act_gp2;

  always_comb begin
    rest = ~hit_io;
    w_io = hit_io;
    if (prog_cfg.gp_first) begin
      w_gp1  = rest & hit_gp1;
      w_gp2  = rest & ~hit_gp1 & hit_gp2;
      w_prog = rest & ~hit_gp1 & ~hit_gp2 & hit_prog;
    end else begin
      w_prog = rest & hit_prog;
      w_gp1  = rest & ~hit_prog & hit_gp1;
      w_gp2  = rest & ~hit_prog & ~hit_gp1 & hit_gp2;
    end
  end

  assign wins = {w_gp2, w_gp1, w_prog, w_io};

  assign act_prog = w_prog | (w_gp1 & gp1_cfg.to_prog) | (w_gp2 & gp2_cfg.to_prog);
  assign act_gp2  = w_gp2 | (w_gp1 & gp1_cfg.to_gp2);

  assign pin_io   = io_cfg.pol_hi  ? w_io    : ~w_io;
  assign pin_prog = ~act_prog;
  assign pin_gp1  = gp1_cfg.pol_hi ? w_gp1   : ~w_gp1;
  assign pin_gp2  = gp2_cfg.pol_hi ? act_gp2 : ~act_gp2;

  always_comb begin
    unique case (1'b1)
      w_io:    stretch = io_cfg.stretch;
      w_prog:  stretch = prog_cfg.stretch;
      w_gp1:   stretch = gp1_cfg.stretch;
      w_gp2:   stretch = gp2_cfg.stretch;
      default: stretch = 2'd0;
    endcase
  end
endmodule

// File: rtl/chip_sel_decode.sv
module chip_sel_decode
  import csd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [RAW-1:0]     cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [EXT_AW-1:0]  ext_addr,
  input  logic               addr_valid,
  input  logic               e_high,
  output logic               sel_io,
  output logic               sel_prog,
  output logic               sel_gp1,
  output logic               sel_gp2,
  output logic [1:0]         stretch
);
  localparam int REG_IO = 0, REG_PROG = 1, REG_GP1 = 2, REG_GP2 = 5;

  logic [NREG-1:0][7:0] regs;
  io_cfg_t              io_cfg;
  prog_cfg_t            prog_cfg;
  gp_cfg_t [1:0]        gp_cfg;
  logic [1:0]           gp_hit;
  logic                 hit_io, hit_prog;
  logic [3:0]           hits, wins;

  csd_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .regs(regs)
  );

  assign io_cfg = '{en: regs[REG_IO][0], qual_any: regs[REG_IO][1],
                    pol_hi: regs[REG_IO][2], size4k: regs[REG_IO][3],
                    stretch: regs[REG_IO][5:4]};
  assign prog_cfg = '{en: regs[REG_PROG][0], size: regs[REG_PROG][2:1],
                      stretch: regs[REG_PROG][4:3], gp_first: regs[REG_PROG][5]};

  for (genvar g = 0; g < 2; g++) begin : g_gp
    localparam int BASE_IX = (g == 0) ? REG_GP1 : REG_GP2;
    assign gp_cfg[g] = '{size: regs[BASE_IX][3:0], qual_any: regs[BASE_IX][4],
                         pol_hi: regs[BASE_IX][5], stretch: regs[BASE_IX][7:6],
                         use_ext: regs[BASE_IX+1][0], to_prog: regs[BASE_IX+1][1],
                         to_gp2: (g == 0) ? regs[BASE_IX+1][2] : 1'b0,
                         base: regs[BASE_IX+2][BASE_W-1:0]};
    csd_gp_match u_match (
      .cfg(gp_cfg[g]), .cpu_addr(cpu_addr), .ext_addr(ext_addr),
      .addr_valid(addr_valid), .e_high(e_high), .hit(gp_hit[g])
    );
  end

  assign hit_io   = io_cfg.en & strobe_ok(io_cfg.qual_any, addr_valid, e_high)
                  & io_region(cpu_addr, io_cfg.size4k);
  assign hit_prog = prog_cfg.en & addr_valid & prog_region(cpu_addr, prog_cfg.size);
  assign hits     = {gp_hit[1], gp_hit[0], hit_prog, hit_io};

  csd_arbiter u_arb (
    .hit_io(hit_io), .hit_prog(hit_prog), .hit_gp1(gp_hit[0]), .hit_gp2(gp_hit[1]),
    .io_cfg(io_cfg), .prog_cfg(prog_cfg), .gp1_cfg(gp_cfg[0]), .gp2_cfg(gp_cfg[1]),
    .wins(wins), .pin_io(sel_io), .pin_prog(sel_prog), .pin_gp1(sel_gp1),
    .pin_gp2(sel_gp2), .stretch(stretch)
  );
endmodule

// File: rtl/csd_checker.sv
module csd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic [7:0] prog_byte,
  input logic       addr_valid,
  input logic [3:0] hits,
  input logic [3:0] wins,
  input logic       sel_prog,
  input logic [1:0] stretch
);
  // R1: a write to program control is visible on the next cycle
  assert_cfg_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd1) |=> (prog_byte == $past(cfg_wdata)));

  // R3: without a valid address the program pin stays inactive
  assert_no_strobe_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> sel_prog);

  // R8: never more than one winner
  assert_single_winner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wins));

  // R8: an I/O hit always wins
  assert_io_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hits[0] |-> wins[0]);

  // R8: a winner must come from a hit
  assert_win_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wins & ~hits) == 4'b0);

  // R10: no winner means no stretch request
  assert_idle_stretch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wins == 4'b0) |-> (stretch == 2'd0));
endmodule

bind chip_sel_decode csd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .prog_byte(regs[1]), .addr_valid(addr_valid),
  .hits(hits), .wins(wins), .sel_prog(sel_prog), .stretch(stretch)
);

// File: tb/chip_sel_decode_tb.sv
module chip_sel_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [15:0] cpu_addr = '0;
  logic [18:0] ext_addr = '0;
  logic        addr_valid = 1'b0;
  logic        e_high = 1'b0;
  logic        sel_io, sel_prog, sel_gp1, sel_gp2;
  logic [1:0]  stretch;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  chip_sel_decode dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .ext_addr(ext_addr),
    .addr_valid(addr_valid), .e_high(e_high), .sel_io(sel_io),
    .sel_prog(sel_prog), .sel_gp1(sel_gp1), .sel_gp2(sel_gp2), .stretch(stretch)
  );

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(input logic [15:0] ca, input logic [18:0] ea,
                     input logic av, input logic e);
    @(negedge clk);
    cpu_addr = ca; ext_addr = ea; addr_valid = av; e_high = e;
    #1;
  endtask

  task automatic chk(input logic eio, input logic eprog, input logic eg1,
                     input logic eg2, input logic [1:0] est, input string req);
    n_run++;
    if ({sel_io, sel_prog, sel_gp1, sel_gp2, stretch} !== {eio, eprog, eg1, eg2, est}) begin
      n_fail++;
      $display("FAIL %s: io/prog/gp1/gp2/stretch got %b%b%b%b/%0d expected %b%b%b%b/%0d",
               req, sel_io, sel_prog, sel_gp1, sel_gp2, stretch,
               eio, eprog, eg1, eg2, est);
    end
  endtask

  task automatic t_reset;
    bus(16'h1234, 19'h0, 1'b1, 1'b1);
    chk(1, 0, 1, 1, 0, "R1 reset state");
    bus(16'h1234, 19'h0, 1'b0, 1'b1);
    chk(1, 1, 1, 1, 0, "R3 prog needs addr_valid");
  endtask

  task automatic t_io;
    wr(3'd0, 8'h21);                        // en, E-qualified, low, 8K, stretch 2
    bus(16'h0800, 19'h0, 1'b1, 1'b1);
    chk(0, 1, 1, 1, 2, "R8 R10 io wins over prog");
    bus(16'h0800, 19'h0, 1'b1, 1'b0);
    chk(1, 0, 1, 1, 0, "R3 io waits for e_high");
    bus(16'h2000, 19'h0, 1'b1, 1'b1);
    chk(1, 0, 1, 1, 0, "R2 io 8K upper edge");
    wr(3'd0, 8'h29);                        // size 4K
    bus(16'h0FFF, 19'h0, 1'b1, 1'b1);
    chk(1, 0, 1, 1, 0, "R2 io 4K below");
    bus(16'h1800, 19'h0, 1'b1, 1'b1);
    chk(0, 1, 1, 1, 2, "R2 io 4K inside");
    wr(3'd0, 8'h0F);                        // any-valid, active high, 4K
    bus(16'h1000, 19'h0, 1'b1, 1'b0);
    chk(1, 1, 1, 1, 0, "R3 R4 io active high without e");
    wr(3'd0, 8'h00);
  endtask

  task automatic t_prog;
    wr(3'd1, 8'h07);
    bus(16'hDFFF, 19'h0, 1'b1, 1'b1); chk(1, 1, 1, 1, 0, "R5 8K below");
    bus(16'hE000, 19'h0, 1'b1, 1'b1); chk(1, 0, 1, 1, 0, "R5 8K base");
    wr(3'd1, 8'h05);
    bus(16'hBFFF, 19'h0, 1'b1, 1'b1); chk(1, 1, 1, 1, 0, "R5 16K below");
    bus(16'hC000, 19'h0, 1'b1, 1'b1); chk(1, 0, 1, 1, 0, "R5 16K base");
    wr(3'd1, 8'h03);
    bus(16'h7FFF, 19'h0, 1'b1, 1'b1); chk(1, 1, 1, 1, 0, "R5 32K below");
    wr(3'd1, 8'h1B);
    bus(16'h8000, 19'h0, 1'b1, 1'b1); chk(1, 0, 1, 1, 3, "R10 prog stretch 3");
    wr(3'd1, 8'h00);
    bus(16'hFFFF, 19'h0, 1'b1, 1'b1); chk(1, 1, 1, 1, 0, "R1 prog disabled");
    wr(3'd1, 8'h01);
  endtask

  task automatic t_gp;
    wr(3'd2, 8'h73);                        // 8K, any-valid, high, stretch 1
    wr(3'd4, 8'h09);                        // low base bits ignored -> 0x4000
    bus(16'h4000, 19'h0, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R8 prog first");
    wr(3'd1, 8'h21);                        // GP first
    bus(16'h4000, 19'h0, 1'b1, 1'b1); chk(1, 1, 1, 1, 1, "R6 R8 gp1 first");
    bus(16'h5FFF, 19'h0, 1'b1, 1'b0); chk(1, 1, 1, 1, 1, "R6 gp1 top edge");
    bus(16'h6000, 19'h0, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R6 gp1 past window");
    bus(16'h3FFF, 19'h0, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R6 gp1 below window");
    wr(3'd2, 8'h7A);                        // size code 10 disables
    bus(16'h4000, 19'h0, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R6 code above 9");
    wr(3'd2, 8'h73);
    wr(3'd3, 8'h01);                        // use expanded address
    wr(3'd4, 8'h48);
    bus(16'h4000, 19'h00000, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R7 cpu addr ignored");
    bus(16'h4000, 19'h24000, 1'b1, 1'b1); chk(1, 1, 1, 1, 1, "R7 ext hit");
    bus(16'h0000, 19'h25FFF, 1'b1, 1'b1); chk(1, 1, 1, 1, 1, "R7 ext top edge");
    bus(16'h4000, 19'h26000, 1'b1, 1'b1); chk(1, 0, 0, 1, 0, "R7 ext past window");
    wr(3'd5, 8'h99);                        // gp2 512K, any-valid, low, stretch 2
    wr(3'd7, 8'h00);
    bus(16'h4000, 19'h24000, 1'b1, 1'b1); chk(1, 1, 1, 1, 1, "R8 gp1 over gp2");
    bus(16'h4000, 19'h00000, 1'b1, 1'b1); chk(1, 1, 0, 0, 2, "R8 R10 gp2 wins");
    wr(3'd3, 8'h05);
    bus(16'h4000, 19'h24000, 1'b1, 1'b1); chk(1, 1, 1, 0, 1, "R9 gp1 onto gp2");
    wr(3'd3, 8'h03);
    bus(16'h4000, 19'h24000, 1'b1, 1'b1); chk(1, 0, 1, 1, 1, "R9 gp1 onto prog");
    wr(3'd3, 8'h01);
    wr(3'd5, 8'h89);                        // gp2 E-qualified
    bus(16'h4000, 19'h00000, 1'b1, 1'b0); chk(1, 0, 0, 1, 0, "R3 gp2 waits for e");
    bus(16'h4000, 19'h00000, 1'b1, 1'b1); chk(1, 1, 0, 0, 2, "R3 gp2 with e");
    bus(16'h4000, 19'h24000, 1'b0, 1'b1); chk(1, 1, 0, 1, 0, "R3 nothing without valid");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_io();
    t_prog();
    t_gp();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule